// File: doc/BRIEF.md
# Windowed Watchdog Timer

A windowed watchdog built around a 12-bit down-counter. The counter steps down by one on every cycle in which the external tick enable is high and counting is not frozen. Software restarts it by writing a keyed restart command. The restart is accepted only while the counter has already fallen to or below a programmable window bound. A restart that arrives too early is a fault. Running past zero is also a fault.

Each fault can raise a level interrupt and request a one-cycle reset pulse. The pulse goes either to the whole system or to the processor alone. The behaviour is fixed by a 32-bit mode register that takes only the first write after reset. Counting can be frozen while a debug-state input or an idle input is high, and it can be switched off entirely.

Bus words are selected by `bus_addr`: 0 is the command word (write only, reads 0), 1 is the mode word, 2 is the status word, 3 is the live counter value.

Top module: `wwdt_ctrl`

## Requirements
- R1: After reset the mode word reads 0x0FFF_0FFF, the counter reads 0xFFF, the status reads 0, and `irq`, `sys_rst_pulse` and `cpu_rst_pulse` are low.
- R2: Mode word fields: reload value bits 11:0, interrupt enable bit 12, reset enable bit 13, processor-only select bit 14, disable bit 15, window bound bits 27:16, debug freeze bit 28, idle freeze bit 29. The first write after reset is stored and loads the counter with the new reload value. Every later write leaves both the mode word and the counter unchanged.
- R3: When counting is enabled, each tick lowers the counter by one. A tick taken at zero is an underflow: it reloads the counter and sets status bit 0.
- R4: With bit 28 set the counter holds while `dbg_state` is high. With bit 29 set it holds while `idle_state` is high.
- R5: A restart is a command write with 0xA5 in bits 31:24 and 1 in bit 0. When the counter is at or below the window bound, a restart reloads the counter and raises no fault.
- R6: A restart while the counter is above the window bound leaves the counter unreloaded and sets status bit 1.
- R7: A command write with any other key changes neither the counter nor the status.
- R8: When a restart and a tick fall in the same cycle, the restart wins: the counter takes the reload value. At zero, no underflow is recorded.
- R9: `irq` is high exactly while bit 12 is set and either status bit is set.
- R10: A fault with bit 13 set produces a one-cycle pulse on `cpu_rst_pulse` in the next cycle. It also pulses `sys_rst_pulse` when bit 14 is 0. With bit 14 at 1, `sys_rst_pulse` stays low.
- R11: With bit 15 set, ticks do not move the counter, and restarts produce no fault and no pulse.
- R12: Reading the status word clears both flags, unless a new fault sets one in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select (0 command, 1 mode, 2 status, 3 counter) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tick | input | 1 | Count enable |
| dbg_state | input | 1 | Processor in debug state |
| idle_state | input | 1 | System in idle state |
| irq | output | 1 | Fault interrupt, level high |
| sys_rst_pulse | output | 1 | Full-system reset request pulse |
| cpu_rst_pulse | output | 1 | Processor reset request pulse |

## Verification
A keyed restart and a counting tick can land on the same clock edge. This matters most when the counter sits at zero, where the tick alone would underflow. The bench drives the restart write and the tick in one cycle, first after counting the counter down to exactly zero. It then judges the outcome by reading back the reload value and a clear status, and by finding no new reset pulse.

// File: rtl/wwdt_ctrl.sv
module wwdt_ctrl #(
  parameter logic [31:0] MODE_INIT = 32'h0FFF_0FFF,
  parameter logic [7:0]  KEY       = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick,
  input  logic        dbg_state,
  input  logic        idle_state,
  output logic        irq,
  output logic        sys_rst_pulse,
  output logic        cpu_rst_pulse
);
  localparam int CW = 12;

  logic [31:0]   mode_q;
  logic          locked;
  logic [CW-1:0] cnt;
  logic          uf_flag, err_flag;

  wire [CW-1:0] reload    = mode_q[11:0];
  wire          irq_en    = mode_q[12];
  wire          rst_en    = mode_q[13];
  wire          cpu_only  = mode_q[14];
  wire          dis       = mode_q[15];
  wire [CW-1:0] window    = mode_q[27:16];
  wire          dbg_frz   = mode_q[28];
  wire          idle_frz  = mode_q[29];

  wire wr_cmd  = bus_sel && bus_wr && bus_addr == 2'd0;
  wire wr_mode = bus_sel && bus_wr && bus_addr == 2'd1;
  wire rd_stat = bus_sel && !bus_wr && bus_addr == 2'd2;

  wire run        = !dis && !(dbg_frz && dbg_state) && !(idle_frz && idle_state);
  wire restart    = wr_cmd && bus_wdata[31:24] == KEY && bus_wdata[0] && !dis;
  wire restart_ok = restart && cnt <= window;
  wire err_evt    = restart && cnt > window;
  wire uf_evt     = run && tick && cnt == '0 && !restart_ok;
  wire fault      = uf_evt || err_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT;
      locked <= 1'b0;
    end else if (wr_mode && !locked) begin
      mode_q <= bus_wdata;
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= MODE_INIT[11:0];
    else if (wr_mode && !locked)
      cnt <= bus_wdata[11:0];
    else if (restart_ok)
      cnt <= reload;
    else if (run && tick)
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_flag       <= 1'b0;
      err_flag      <= 1'b0;
      sys_rst_pulse <= 1'b0;
      cpu_rst_pulse <= 1'b0;
    end else begin
      uf_flag       <= uf_evt  || (uf_flag  && !rd_stat);
      err_flag      <= err_evt || (err_flag && !rd_stat);
      sys_rst_pulse <= fault && rst_en && !cpu_only;
      cpu_rst_pulse <= fault && rst_en;
    end
  end

  assign irq = irq_en && (uf_flag || err_flag);

  always_comb begin
    case (bus_addr)
      2'd1:    bus_rdata = mode_q;
      2'd2:    bus_rdata = {30'd0, err_flag, uf_flag};
      2'd3:    bus_rdata = {{(32-CW){1'b0}}, cnt};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

module wwdt_ctrl_chk #(
  parameter logic [7:0] KEY = 8'hA5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        tick,
  input logic        dbg_state,
  input logic        idle_state,
  input logic [31:0] mode_q,
  input logic        locked,
  input logic [11:0] cnt,
  input logic        err_flag,
  input logic        err_evt,
  input logic        sys_rst_pulse,
  input logic        cpu_rst_pulse
);
  // R2
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mode_q));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !mode_q[15] && !(mode_q[28] && dbg_state) && !(mode_q[29] && idle_state)
     && tick && cnt != 12'd0 && !(bus_sel && bus_wr))
    |=> cnt == $past(cnt) - 12'd1);

  // R6
  early_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd0 && bus_wdata[31:24] == KEY && bus_wdata[0]
     && !mode_q[15] && cnt > mode_q[27:16]) |=> err_flag);

  // R10
  sys_implies_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> cpu_rst_pulse);

  // R10
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_pulse |-> $past(mode_q[13]));

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && mode_q[15]) |=> ($stable(cnt) && !cpu_rst_pulse));

  // R12
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 2'd2 && !err_evt) |=> !err_flag);
endmodule

bind wwdt_ctrl wwdt_ctrl_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tick(tick), .dbg_state(dbg_state), .idle_state(idle_state),
  .mode_q(mode_q), .locked(locked), .cnt(cnt), .err_flag(err_flag), .err_evt(err_evt),
  .sys_rst_pulse(sys_rst_pulse), .cpu_rst_pulse(cpu_rst_pulse)
);

// File: tb/sim_wwdt_ctrl.sv
`timescale 1ns/1ps
module sim_wwdt_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tick = 0, dbg_state = 0, idle_state = 0;
  logic irq, sys_rst_pulse, cpu_rst_pulse;

  always #2 clk = ~clk;

  wwdt_ctrl u0 (.*);

  typedef struct { logic [1:0] addr; logic [31:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0, sys_n = 0, cpu_n = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (sys_rst_pulse) sys_n++;
    if (cpu_rst_pulse) cpu_n++;
    if (bus_sel && !bus_wr) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++; $display("FAIL %s unexpected read act=%h exp=none", "SB", bus_rdata);
      end else begin
        it = sb.pop_front();
        if (bus_rdata !== it.exp || bus_addr !== it.addr) begin
          errors++;
          $display("FAIL %s addr=%0d act=%h exp=%h", it.req, bus_addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] e, string req);
    item_t it;
    it.addr = a; it.exp = e; it.req = req;
    sb.push_back(it);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic with_tick);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick = with_tick;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pulses", {30'd0, sys_rst_pulse, cpu_rst_pulse}, 0);
    rd(2'd1, 32'h0FFF_0FFF, "R1 mode");
    rd(2'd3, 32'h0000_0FFF, "R1 count");
    rd(2'd2, 32'h0, "R1 status");

    // R2 first write stored, loads counter; second ignored
    wr(2'd1, 32'h3008_3010, 0);
    rd(2'd1, 32'h3008_3010, "R2 mode stored");
    rd(2'd3, 32'h10, "R2 counter loaded");
    wr(2'd1, 32'h0000_8005, 0);
    rd(2'd1, 32'h3008_3010, "R2 second write ignored");
    rd(2'd3, 32'h10, "R2 counter untouched");

    // R3 counting
    ticks(5);
    rd(2'd3, 32'h0B, "R3 five ticks");

    // R4 freezes
    dbg_state = 1; ticks(3); dbg_state = 0;
    rd(2'd3, 32'h0B, "R4 debug freeze");
    idle_state = 1; ticks(3); idle_state = 0;
    rd(2'd3, 32'h0B, "R4 idle freeze");

    // R6 early restart
    wr(2'd0, 32'hA500_0001, 0);
    chk("R9 irq on error", {31'd0, irq}, 1);
    rd(2'd3, 32'h0B, "R6 no reload");
    rd(2'd2, 32'h2, "R6 error flag");
    rd(2'd2, 32'h0, "R12 cleared by read");
    chk("R9 irq drops", {31'd0, irq}, 0);
    chk("R10 sys pulse count", sys_n, 1);
    chk("R10 cpu pulse count", cpu_n, 1);

    // R7 wrong key
    wr(2'd0, 32'h5A00_0001, 0);
    rd(2'd2, 32'h0, "R7 no error");
    rd(2'd3, 32'h0B, "R7 no reload");

    // R5 legal restart
    ticks(3);
    rd(2'd3, 32'h08, "R3 at window bound");
    wr(2'd0, 32'hA500_0001, 0);
    rd(2'd3, 32'h10, "R5 reloaded");
    rd(2'd2, 32'h0, "R5 no fault");

    // R8 restart with tick at zero
    ticks(16);
    rd(2'd3, 32'h0, "R3 reached zero");
    wr(2'd0, 32'hA500_0001, 1);
    rd(2'd3, 32'h10, "R8 restart wins");
    rd(2'd2, 32'h0, "R8 no underflow");
    chk("R8 no pulse", cpu_n, 1);

    // R3 underflow
    ticks(17);
    chk("R9 irq on underflow", {31'd0, irq}, 1);
    rd(2'd3, 32'h10, "R3 underflow reload");
    rd(2'd2, 32'h1, "R3 underflow flag");
    chk("R10 sys pulse after underflow", sys_n, 2);
    chk("R10 cpu pulse after underflow", cpu_n, 2);

    // R11 disabled
    do_reset();
    rd(2'd1, 32'h0FFF_0FFF, "R1 mode after reset");
    wr(2'd1, 32'h0000_E004, 0);
    ticks(10);
    rd(2'd3, 32'h4, "R11 counter frozen");
    wr(2'd0, 32'hA500_0001, 0);
    rd(2'd2, 32'h0, "R11 no fault");
    chk("R11 no cpu pulse", cpu_n, 2);

    // R10 processor-only scope, R9 irq masked
    do_reset();
    wr(2'd1, 32'h0000_6002, 0);
    ticks(3);
    chk("R9 irq masked", {31'd0, irq}, 0);
    rd(2'd2, 32'h1, "R3 underflow with mask");
    @(posedge clk); #1;
    chk("R10 sys unchanged", sys_n, 2);
    chk("R10 cpu pulse", cpu_n, 3);

    repeat (2) @(posedge clk);
    chk("SB drained", sb.size(), 0);
    finish_run();
  end
endmodule